// File: doc/BRIEF.md
# Reset Cause Controller

This block collects every request that may reset the chip and turns them into a single internal reset pulse. It also remembers which request caused the most recent reset. Some requests are always live: power-on, the external active-low reset pin and the watchdog timeout. The supply monitor, the missing-clock detector, the comparator and the convert-start input each count only when software has enabled them. Software can also force two kinds of reset.

Software sees one 8-bit register whose two directions hold different state. A write stores the source enables and may fire a force pulse. A read returns the one-hot cause of the last reset. Each reset request restarts a hold counter. The internal reset stays asserted until that counter has run out with no request present. A forced power-on-class reset also drives the external reset pin low for the same window.

All request inputs are assumed to be synchronous to `clk` already. `porReq` acts as an asynchronous reset for the block's own state.

Top module: `rstCauseCtl`

## Requirements
- R1: While `porReq` is high and after it falls, the read value is 0x02, every enable is cleared and `sysRstOut` is high.
- R2: Read bit 7 is always 0. The read value is one-hot with this layout: bit 6 convert-start, bit 5 comparator, bit 4 software, bit 3 watchdog, bit 2 missing-clock, bit 1 power-on or supply, bit 0 pin.
- R3: A low level on `pinRstN` always causes a reset, and the read value becomes 0x01.
- R4: A high level on `wdtTimeoutReq` always causes a reset, and the read value becomes 0x08.
- R5: `clkMissingReq` causes a reset with read value 0x04 only while write bit 2 is stored as 1. Otherwise it has no effect.
- R6: A low `cmpOutN` causes a reset with read value 0x20 only while write bit 5 is stored. A low `convStartN` causes a reset with read value 0x40 only while write bit 6 is stored.
- R7: `supplyLowReq` causes a reset only while write bit 1 is stored and `monitorPinEn` is high. The read value becomes 0x02 and all enables are cleared.
- R8: Writing 1 to bit 4 forces a reset with read value 0x10. `pinDriveLowOut` stays low and the stored enables are kept.
- R9: Writing 1 to bit 0 forces a power-on-class reset. The read value becomes 0x02, the enables are cleared, and `pinDriveLowOut` stays high for as long as `sysRstOut`.
- R10: Writing 0 to bits 4 and 0 starts no reset and leaves the read value unchanged.
- R11: When several requests arrive in the same cycle, the recorded cause follows this priority: power-on/supply, pin, missing-clock, watchdog, software, comparator, convert-start.
- R12: `sysRstOut` rises one edge after a request is seen. It falls once HOLD_CYCLES rising edges have passed with no request present.
- R13: Register writes made while `sysRstOut` is high are ignored. They neither force a reset nor change the enables.
- R14: Resets that are not power-on-class keep the stored enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porReq | input | 1 | Power-on request, active high; also the asynchronous reset of the block's state |
| supplyLowReq | input | 1 | Supply monitor trip, active high |
| monitorPinEn | input | 1 | Level of the monitor-enable strap |
| pinRstN | input | 1 | External reset pin, active low |
| wdtTimeoutReq | input | 1 | Watchdog timeout, active high |
| clkMissingReq | input | 1 | Missing-clock detector trip, active high |
| cmpOutN | input | 1 | Comparator output, active low |
| convStartN | input | 1 | Convert-start input, active low |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data: the cause of the last reset |
| sysRstOut | output | 1 | Internal reset pulse |
| pinDriveLowOut | output | 1 | Drives the external reset pin low during a forced power-on-class reset |

## Verification
The bench targets the split between the write and read meanings of the register. A design that read back the enables, or stored the force bits, would return a wrong cause or fire a second reset. It fires mixed requests in the same cycle to expose a wrong priority order. It also checks that power-on-class resets clear the enables and that other resets keep them. A design that got this wrong would either let a disabled comparator reset the chip or block an enabled one. Finally, it tries writes during the hold window and counts the exact pulse length. An off-by-one counter, or a write accepted during reset, shows up as a length or cause mismatch.

// File: rtl/rccPkg.sv
package rccPkg;
  localparam int CAUSE_W = 7;
  localparam int B_PIN = 0;
  localparam int B_POR = 1;
  localparam int B_MCD = 2;
  localparam int B_WDT = 3;
  localparam int B_SW  = 4;
  localparam int B_CMP = 5;
  localparam int B_CNV = 6;
  // highest priority first
  localparam int PRIO_ORDER [CAUSE_W] = '{B_POR, B_PIN, B_MCD, B_WDT, B_SW, B_CMP, B_CNV};

  typedef struct packed {
    logic cnv;
    logic cmp;
    logic mcd;
    logic sup;
  } enable_t;

  typedef struct packed {
    logic               causeLoad;
    logic [CAUSE_W-1:0] causeVec;
    logic               enWrite;
    logic               enClear;
    enable_t            enData;
  } strobe_t;
endpackage

// File: rtl/rccControl.sv
module rccControl
  import rccPkg::*;
#(
  parameter int HOLD_CYCLES = 16
) (
  input  logic         clk,
  input  logic         porReq,
  input  logic         supplyLowReq,
  input  logic         monitorPinEn,
  input  logic         pinRstN,
  input  logic         wdtTimeoutReq,
  input  logic         clkMissingReq,
  input  logic         cmpOutN,
  input  logic         convStartN,
  input  logic         regWrEn,
  input  logic [7:0]   regWrData,
  input  enable_t      enables,
  output strobe_t      strobe,
  output logic         sysRstOut,
  output logic         pinDriveLowOut
);
  localparam int CNT_W = $clog2(HOLD_CYCLES + 1);

  logic [CNT_W-1:0]   holdCnt;
  logic               pinFlag;
  logic               inReset;
  logic               wrOk;
  logic               forceSw;
  logic               forcePor;
  logic               supReq;
  logic               anyReq;
  logic [CAUSE_W-1:0] rawReq;
  logic [CAUSE_W-1:0] causeVec;
  logic               unusedWrBits;

  assign unusedWrBits = ^{regWrData[7], regWrData[3]};

  assign inReset  = (holdCnt != '0);
  assign wrOk     = regWrEn && !inReset;
  assign forceSw  = wrOk && regWrData[B_SW];
  assign forcePor = wrOk && regWrData[0];
  assign supReq   = enables.sup && monitorPinEn && supplyLowReq;

  always_comb begin
    rawReq        = '0;
    rawReq[B_POR] = forcePor || supReq;
    rawReq[B_PIN] = !pinRstN;
    rawReq[B_MCD] = enables.mcd && clkMissingReq;
    rawReq[B_WDT] = wdtTimeoutReq;
    rawReq[B_SW]  = forceSw;
    rawReq[B_CMP] = enables.cmp && !cmpOutN;
    rawReq[B_CNV] = enables.cnv && !convStartN;
  end

  // priority pick: first hit in PRIO_ORDER wins
  always_comb begin
    logic hit;
    hit      = 1'b0;
    causeVec = '0;
    for (int i = 0; i < CAUSE_W; i++) begin
      if (!hit && rawReq[PRIO_ORDER[i]]) begin
        causeVec[PRIO_ORDER[i]] = 1'b1;
        hit = 1'b1;
      end
    end
  end

  assign anyReq = |rawReq;

  always_comb begin
    strobe.causeLoad = anyReq;
    strobe.causeVec  = causeVec;
    strobe.enWrite   = wrOk;
    strobe.enClear   = rawReq[B_POR];
    strobe.enData    = '{cnv: regWrData[B_CNV], cmp: regWrData[B_CMP],
                         mcd: regWrData[B_MCD], sup: regWrData[B_POR]};
  end

  always_ff @(posedge clk or posedge porReq) begin
    if (porReq) begin
      holdCnt <= CNT_W'(HOLD_CYCLES);
      pinFlag <= 1'b0;
    end else begin
      if (anyReq)
        holdCnt <= CNT_W'(HOLD_CYCLES);
      else if (inReset)
        holdCnt <= holdCnt - 1'b1;

      if (forcePor)
        pinFlag <= 1'b1;
      else if (!anyReq && holdCnt == CNT_W'(1))
        pinFlag <= 1'b0;
    end
  end

  assign sysRstOut      = inReset;
  assign pinDriveLowOut = pinFlag;
endmodule

// File: rtl/rccDatapath.sv
module rccDatapath
  import rccPkg::*;
(
  input  logic       clk,
  input  logic       porReq,
  input  strobe_t    strobe,
  output enable_t    enables,
  output logic [7:0] regRdData
);
  logic [CAUSE_W-1:0] causeReg;
  enable_t            enReg;

  always_ff @(posedge clk or posedge porReq) begin
    if (porReq) begin
      causeReg <= CAUSE_W'(1) << B_POR;
      enReg    <= '0;
    end else begin
      if (strobe.causeLoad)
        causeReg <= strobe.causeVec;
      if (strobe.enClear)
        enReg <= '0;
      else if (strobe.enWrite)
        enReg <= strobe.enData;
    end
  end

  assign enables   = enReg;
  assign regRdData = {1'b0, causeReg};
endmodule

// File: rtl/rstCauseCtl.sv
module rstCauseCtl
  import rccPkg::*;
#(
  parameter int HOLD_CYCLES = 16
) (
  input  logic       clk,
  input  logic       porReq,
  input  logic       supplyLowReq,
  input  logic       monitorPinEn,
  input  logic       pinRstN,
  input  logic       wdtTimeoutReq,
  input  logic       clkMissingReq,
  input  logic       cmpOutN,
  input  logic       convStartN,
  input  logic       regWrEn,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  output logic       sysRstOut,
  output logic       pinDriveLowOut
);
  strobe_t strobe;
  enable_t enables;

  rccControl #(.HOLD_CYCLES(HOLD_CYCLES)) ctl_i (
    .clk(clk), .porReq(porReq), .supplyLowReq(supplyLowReq),
    .monitorPinEn(monitorPinEn), .pinRstN(pinRstN),
    .wdtTimeoutReq(wdtTimeoutReq), .clkMissingReq(clkMissingReq),
    .cmpOutN(cmpOutN), .convStartN(convStartN), .regWrEn(regWrEn),
    .regWrData(regWrData), .enables(enables), .strobe(strobe),
    .sysRstOut(sysRstOut), .pinDriveLowOut(pinDriveLowOut)
  );

  rccDatapath dp_i (
    .clk(clk), .porReq(porReq), .strobe(strobe),
    .enables(enables), .regRdData(regRdData)
  );
endmodule

// File: rtl/rccChecker.sv
module rccChecker (
  input logic       clk,
  input logic       porReq,
  input logic       supplyLowReq,
  input logic       monitorPinEn,
  input logic       pinRstN,
  input logic       wdtTimeoutReq,
  input logic       regWrEn,
  input logic [7:0] regWrData,
  input logic [7:0] regRdData,
  input logic       sysRstOut,
  input logic       pinDriveLowOut
);
  assert_onehot_cause_R2: assert property (@(posedge clk) disable iff (porReq)
    (regRdData[7] == 1'b0) && ($countones(regRdData) == 1));

  assert_pin_cause_R3: assert property (@(posedge clk) disable iff (porReq)
    (!pinRstN && !(regWrEn && regWrData[0] && !sysRstOut) && !(supplyLowReq && monitorPinEn))
    |=> (regRdData == 8'h01));

  assert_req_starts_R12: assert property (@(posedge clk) disable iff (porReq)
    (!pinRstN || wdtTimeoutReq) |=> sysRstOut);

  assert_quiet_before_fall_R12: assert property (@(posedge clk) disable iff (porReq)
    $fell(sysRstOut) |-> $past(pinRstN && !wdtTimeoutReq));

  assert_pin_within_reset_R9: assert property (@(posedge clk) disable iff (porReq)
    pinDriveLowOut |-> sysRstOut);

  assert_sw_no_pin_R8: assert property (@(posedge clk) disable iff (porReq)
    (regWrEn && regWrData[4] && !regWrData[0] && !sysRstOut && !pinDriveLowOut)
    |=> !pinDriveLowOut);
endmodule

bind rstCauseCtl rccChecker chk_i (
  .clk(clk), .porReq(porReq), .supplyLowReq(supplyLowReq),
  .monitorPinEn(monitorPinEn), .pinRstN(pinRstN),
  .wdtTimeoutReq(wdtTimeoutReq), .regWrEn(regWrEn), .regWrData(regWrData),
  .regRdData(regRdData), .sysRstOut(sysRstOut), .pinDriveLowOut(pinDriveLowOut)
);

// File: tb/rstCauseCtl_tb_top.sv
module rstCauseCtl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 16;
  // request mask bits used by the bench
  localparam logic [5:0] M_PIN = 6'h01, M_WDT = 6'h02, M_MCD = 6'h04,
                         M_CMP = 6'h08, M_CNV = 6'h10, M_SUP = 6'h20;
  // observation selectors
  localparam int S_RD = 0, S_RST = 1, S_PIN = 2, S_LEN = 3, S_PLEN = 4;

  logic       clk = 1'b0;
  logic       porReq = 1'b0;
  logic       supplyLowReq = 1'b0;
  logic       monitorPinEn = 1'b1;
  logic       pinRstN = 1'b1;
  logic       wdtTimeoutReq = 1'b0;
  logic       clkMissingReq = 1'b0;
  logic       cmpOutN = 1'b1;
  logic       convStartN = 1'b1;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] regRdData;
  logic       sysRstOut;
  logic       pinDriveLowOut;

  rstCauseCtl #(.HOLD_CYCLES(HOLD)) dut_i (
    .clk(clk), .porReq(porReq), .supplyLowReq(supplyLowReq),
    .monitorPinEn(monitorPinEn), .pinRstN(pinRstN),
    .wdtTimeoutReq(wdtTimeoutReq), .clkMissingReq(clkMissingReq),
    .cmpOutN(cmpOutN), .convStartN(convStartN), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .sysRstOut(sysRstOut),
    .pinDriveLowOut(pinDriveLowOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    string tag;
    int    sel;
    int    exp;
  } item_t;

  item_t expQ[$];
  int checks = 0;
  int errors = 0;
  int lenObs = 0;
  int pinObs = 0;
  bit done = 1'b0;

  function automatic int observe(int sel);
    case (sel)
      S_RD:    return int'(regRdData);
      S_RST:   return int'(sysRstOut);
      S_PIN:   return int'(pinDriveLowOut);
      S_LEN:   return lenObs;
      default: return pinObs;
    endcase
  endfunction

  // monitor: pops expectations at each falling edge and compares
  always @(negedge clk) begin
    item_t it;
    int got;
    while (expQ.size() > 0) begin
      it  = expQ.pop_front();
      got = observe(it.sel);
      checks++;
      if (got != it.exp) begin
        errors++;
        $display("FAIL %s: actual=0x%0h expected=0x%0h", it.tag, got, it.exp);
      end
    end
  end

  task automatic expectv(string tag, int sel, int exp);
    item_t it;
    it.tag = tag; it.sel = sel; it.exp = exp;
    expQ.push_back(it);
  endtask

  task automatic tick();
    @(negedge clk);
    #3;
  endtask

  task automatic setReqs(logic [5:0] m);
    pinRstN       = !m[0];
    wdtTimeoutReq = m[1];
    clkMissingReq = m[2];
    cmpOutN       = !m[3];
    convStartN    = !m[4];
    supplyLowReq  = m[5];
  endtask

  // one cycle of requests and/or a register write
  task automatic fire(logic [5:0] m, logic doWr, logic [7:0] wd);
    setReqs(m);
    regWrEn   = doWr;
    regWrData = wd;
    tick();
    setReqs('0);
    regWrEn   = 1'b0;
    regWrData = 8'h00;
  endtask

  task automatic measure();
    lenObs = 0;
    pinObs = 0;
    do begin
      @(posedge clk);
      lenObs++;
      @(negedge clk);
      #3;
      if (pinDriveLowOut) pinObs++;
    end while (sysRstOut && lenObs < 200);
  endtask

  task automatic expectReset(string tag, logic [5:0] m, logic doWr, logic [7:0] wd,
                             int cause, int pinLen);
    fire(m, doWr, wd);
    measure();
    expectv({tag, " length"}, S_LEN, HOLD);
    expectv({tag, " cause"}, S_RD, cause);
    expectv({tag, " pin drive"}, S_PLEN, pinLen);
    tick();
  endtask

  task automatic expectIgnored(string tag, logic [5:0] m, logic doWr, logic [7:0] wd,
                               int cause);
    fire(m, doWr, wd);
    expectv({tag, " no reset"}, S_RST, 0);
    tick();
    expectv({tag, " cause kept"}, S_RD, cause);
    tick();
  endtask

  initial begin
    #1 porReq = 1'b1;
    tick(); tick();
    expectv("R1 reset during power-on", S_RST, 1);
    expectv("R1 cause during power-on", S_RD, 8'h02);
    tick();
    porReq = 1'b0;
    measure();
    expectv("R12 power-on release length", S_LEN, HOLD);
    expectv("R2 bit7 clear, one-hot power-on cause", S_RD, 8'h02);
    tick();
    expectIgnored("R1 enables cleared, comparator", M_CMP, 1'b0, 8'h00, 8'h02);
    expectReset("R3 pin reset", M_PIN, 1'b0, 8'h00, 8'h01, 0);
    expectReset("R4 watchdog reset", M_WDT, 1'b0, 8'h00, 8'h08, 0);
    expectIgnored("R5 missing-clock while disabled", M_MCD, 1'b0, 8'h00, 8'h08);
    expectIgnored("R10 enable write with zero force bits", 6'h00, 1'b1, 8'h64, 8'h08);
    expectReset("R5 missing-clock enabled", M_MCD, 1'b0, 8'h00, 8'h04, 0);
    expectReset("R14 comparator after non-power reset", M_CMP, 1'b0, 8'h00, 8'h20, 0);
    expectReset("R6 convert-start enabled", M_CNV, 1'b0, 8'h00, 8'h40, 0);
    expectReset("R8 software force", 6'h00, 1'b1, 8'h74, 8'h10, 0);
    expectReset("R8 enables kept after software force", M_CMP, 1'b0, 8'h00, 8'h20, 0);
    // R13: writes during the hold window
    fire(M_PIN, 1'b0, 8'h00);
    tick();
    fire(6'h00, 1'b1, 8'h10);
    while (sysRstOut) tick();
    expectv("R13 cause unchanged by write during reset", S_RD, 8'h01);
    tick();
    expectReset("R13 enables unchanged by write during reset", M_CMP, 1'b0, 8'h00, 8'h20, 0);
    // R7 supply monitor gating
    expectIgnored("R7 supply with enable bit clear", M_SUP, 1'b0, 8'h00, 8'h20);
    expectIgnored("R7 enable supply source", 6'h00, 1'b1, 8'h66, 8'h20);
    monitorPinEn = 1'b0;
    expectIgnored("R7 supply with strap low", M_SUP, 1'b0, 8'h00, 8'h20);
    monitorPinEn = 1'b1;
    expectReset("R7 supply reset", M_SUP, 1'b0, 8'h00, 8'h02, 0);
    expectIgnored("R7 enables cleared after supply reset", M_CMP, 1'b0, 8'h00, 8'h02);
    // R9 forced power-on-class reset
    expectReset("R9 forced power-on", 6'h00, 1'b1, 8'h21, 8'h02, HOLD-1);
    expectIgnored("R9 enables cleared after forced power-on", M_CMP, 1'b0, 8'h00, 8'h02);
    // R11 priority
    expectIgnored("R11 enable all sources", 6'h00, 1'b1, 8'h66, 8'h02);
    expectReset("R11 pin over watchdog and comparator", M_PIN|M_WDT|M_CMP, 1'b0, 8'h00, 8'h01, 0);
    expectReset("R11 missing-clock over watchdog", M_WDT|M_MCD|M_CNV, 1'b0, 8'h00, 8'h04, 0);
    expectReset("R11 comparator over convert-start", M_CMP|M_CNV, 1'b0, 8'h00, 8'h20, 0);
    expectReset("R11 watchdog over software", M_WDT, 1'b1, 8'h76, 8'h08, 0);
    expectReset("R11 supply over pin", M_SUP|M_PIN, 1'b0, 8'h00, 8'h02, 0);
    tick();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule